// File: doc/BRIEF.md
# Parallel Data Capture Controller

This block watches a set of asynchronous event lines and, on a chosen one, samples an external parallel data bus. Samples of 8, 16 or 32 bits are packed, lowest lane first, into 32-bit words. Each finished word comes out with a one-cycle transfer request for a downstream RAM writer. Software configures the block through a small register write port. One address holds the control fields and the other loads a capture down-counter.

Capture is armed by a capture-enable flag. Software can set it directly, or it can be set by a hardware event chosen through the enable-source field. A second event, chosen through the disable-source field, disarms that hardware source. The down-counter bounds a capture session. The capture that drains it is still stored, its word is flushed even when only partly filled, the enable drops, and the counter stays at zero.

Top module: `pcap_top`

## Requirements
- R1: After synchronous reset, `xfer_req` and `cap_en_o` are 0, `en_src_o` is 0 and `cnt_o` is 0.
- R2: Each event line goes through a two-flop synchronizer, and an event is a rising edge on the synchronized line. When a line is first high at clock edge k, its action is registered at edge k+2.
- R3: Control register layout (address 0): bit 0 is the enable, bits 3:1 are the enable source, bits 5:4 are the disable source, bits 7:6 are the width and bits 9:8 are the capture line. A control write with bit 0 = 1 and an enable-source value of 0 sets `cap_en_o`. A control write with bit 0 = 0 clears it.
- R4: A control write with bit 0 = 1 and a nonzero enable-source value leaves `cap_en_o` unchanged.
- R5: An enable-source value s of 1..7 sets `cap_en_o` on an event on line s. The value 0 never lets any event set it.
- R6: A disable-source value d of 1..3 clears the enable-source field to 0 on an event on line d. The value 0 selects no line.
- R7: A capture is accepted only on an event on the line whose number equals the capture-line field (0..3), while capture is enabled and the counter is nonzero. Address 1 loads the counter, and each accepted capture decrements it by one.
- R8: A capture event in the same cycle that enable becomes 1 (by hardware event or software write) is accepted.
- R9: The width code selects the packing. Code 00 stores data bits 7:0 into byte lanes 0,1,2,3 in turn, with a request every fourth capture. Code 01 stores data bits 15:0 into half 0 then half 1, with a request every second capture. Codes 10 and 11 take the full 32 bits, with a request on every capture. The request lasts one cycle and is registered at the same edge as the capture.
- R10: The capture that brings the counter to 0 is stored and its word is flushed at once, with unfilled lanes reading 0. `cap_en_o` then drops, and the counter stays at 0 with no further captures until it is reloaded.
- R11: When a control write clears the enable, the partial word is discarded and the packing index returns to lane 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 2**ENSEL_W | Asynchronous event lines |
| data_i | input | WORD_W | External parallel data bus |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects control, 1 selects the counter |
| wr_data | input | WORD_W | Register write data |
| xfer_req | output | 1 | One-cycle transfer request |
| xfer_data | output | WORD_W | Packed word that goes with the request |
| cap_en_o | output | 1 | Capture-enable state |
| en_src_o | output | ENSEL_W | Current enable-source field |
| cnt_o | output | CNT_W | Remaining capture count |

## Verification
The bench builds the block with CNT_W = 4 and the default 32-bit word and eight event lines. This keeps every session short enough to sweep all four width codes against every count from 1 to 6. That sweep covers each possible partial-word remainder at exhaustion, as well as full words. With the 4-bit counter, the stop-at-zero behaviour and the arming, disarming and line-select cases each complete in a few dozen cycles, and expected words are rebuilt arithmetically from the data sequence.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

  typedef enum logic [1:0] {
    WID_8   = 2'b00,
    WID_16  = 2'b01,
    WID_32  = 2'b10,
    WID_32B = 2'b11
  } width_e;

  // Packing index value of the final lane in a word
  function automatic logic [1:0] top_lane(width_e w);
    case (w)
      WID_8:   return 2'd3;
      WID_16:  return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/pcap_sync.sv
module pcap_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] rise_o
);

  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-1:0], in_i[g]};
    end
    assign rise_o[g] = sh[STAGES-1] & ~sh[STAGES];
  end

endmodule

// File: rtl/pcap_ctrl.sv
module pcap_ctrl
  import pcap_pkg::*;
#(
  parameter int ENSEL_W = 3,
  parameter int CNT_W   = 16,
  parameter int WORD_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2**ENSEL_W-1:0] rise,
  input  logic                 wr_en,
  input  logic                 wr_addr,
  input  logic [WORD_W-1:0]    wr_data,
  output logic                 cap_en,
  output logic [ENSEL_W-1:0]   en_sel,
  output logic [1:0]           dis_sel,
  output width_e               width,
  output logic [1:0]           cap_sel,
  output logic [CNT_W-1:0]     cnt,
  output logic                 en_eff,
  output logic                 accept,
  output logic                 last
);

  localparam int ENS_LSB = 1;
  localparam int DIS_LSB = ENS_LSB + ENSEL_W;
  localparam int WID_LSB = DIS_LSB + 2;
  localparam int CSL_LSB = WID_LSB + 2;

  logic               ctl_wr, cnt_wr, sw_set, sw_clr, hw_set, dis_hit;
  logic [ENSEL_W-1:0] wd_ensel;

  always_comb begin
    ctl_wr   = wr_en && !wr_addr;
    cnt_wr   = wr_en && wr_addr;
    wd_ensel = wr_data[ENS_LSB +: ENSEL_W];
    sw_clr   = ctl_wr && !wr_data[0];
    sw_set   = ctl_wr && wr_data[0] && (wd_ensel == '0);
    hw_set   = (en_sel != '0) && rise[en_sel];
    dis_hit  = (dis_sel != 2'd0) && rise[dis_sel];
    en_eff   = (cap_en || hw_set || sw_set) && !sw_clr;
    accept   = en_eff && rise[cap_sel] && (cnt != '0) && !cnt_wr;
    last     = accept && (cnt == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_en  <= 1'b0;
      en_sel  <= '0;
      dis_sel <= 2'd0;
      width   <= WID_8;
      cap_sel <= 2'd0;
      cnt     <= '0;
    end else begin
      cap_en <= en_eff && !last;
      if (ctl_wr) begin
        en_sel  <= wd_ensel;
        dis_sel <= wr_data[DIS_LSB +: 2];
        width   <= width_e'(wr_data[WID_LSB +: 2]);
        cap_sel <= wr_data[CSL_LSB +: 2];
      end else if (dis_hit) begin
        en_sel  <= '0;
      end
      if (cnt_wr)      cnt <= wr_data[CNT_W-1:0];
      else if (accept) cnt <= cnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/pcap_packer.sv
module pcap_packer
  import pcap_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              last,
  input  logic              keep,
  input  width_e            width,
  input  logic [WORD_W-1:0] data_i,
  output logic              xfer_req,
  output logic [WORD_W-1:0] xfer_data
);

  localparam int QW = WORD_W / 4;
  localparam int HW = WORD_W / 2;

  logic [WORD_W-1:0] word, merged;
  logic [1:0]        idx;
  logic              full;

  always_comb begin
    merged = word;
    case (width)
      WID_8:   merged[idx*QW +: QW]    = data_i[QW-1:0];
      WID_16:  merged[idx[0]*HW +: HW] = data_i[HW-1:0];
      default: merged = data_i;
    endcase
    full = last || (idx == top_lane(width));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word      <= '0;
      idx       <= 2'd0;
      xfer_req  <= 1'b0;
      xfer_data <= '0;
    end else begin
      xfer_req <= 1'b0;
      if (accept) begin
        if (full) begin
          xfer_data <= merged;
          xfer_req  <= 1'b1;
          word      <= '0;
          idx       <= 2'd0;
        end else begin
          word <= merged;
          idx  <= idx + 2'd1;
        end
      end else if (!keep) begin
        word <= '0;
        idx  <= 2'd0;
      end
    end
  end

endmodule

// File: rtl/pcap_top.sv
module pcap_top
  import pcap_pkg::*;
#(
  parameter int ENSEL_W = 3,
  parameter int CNT_W   = 16,
  parameter int WORD_W  = 32,
  parameter int SYNC_N  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2**ENSEL_W-1:0] evt_i,
  input  logic [WORD_W-1:0]     data_i,
  input  logic                  wr_en,
  input  logic                  wr_addr,
  input  logic [WORD_W-1:0]     wr_data,
  output logic                  xfer_req,
  output logic [WORD_W-1:0]     xfer_data,
  output logic                  cap_en_o,
  output logic [ENSEL_W-1:0]    en_src_o,
  output logic [CNT_W-1:0]      cnt_o
);

  localparam int NUM_EVT = 2**ENSEL_W;

  logic [NUM_EVT-1:0] rise_v;
  logic [1:0]         dis_sel, cap_sel;
  width_e             width;
  logic               en_eff, accept, last;

  pcap_sync #(.N(NUM_EVT), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .in_i(evt_i), .rise_o(rise_v)
  );

  pcap_ctrl #(.ENSEL_W(ENSEL_W), .CNT_W(CNT_W), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst(rst), .rise(rise_v),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_en(cap_en_o), .en_sel(en_src_o), .dis_sel(dis_sel),
    .width(width), .cap_sel(cap_sel), .cnt(cnt_o),
    .en_eff(en_eff), .accept(accept), .last(last)
  );

  pcap_packer #(.WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst(rst), .accept(accept), .last(last), .keep(en_eff),
    .width(width), .data_i(data_i),
    .xfer_req(xfer_req), .xfer_data(xfer_data)
  );

endmodule

// File: rtl/pcap_top_chk.sv
module pcap_top_chk #(
  parameter int ENSEL_W = 3,
  parameter int CNT_W   = 16,
  parameter int WORD_W  = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic [2**ENSEL_W-1:0] rise_v,
  input logic [1:0]            dis_sel,
  input logic                  wr_en,
  input logic                  wr_addr,
  input logic [WORD_W-1:0]     wr_data,
  input logic                  xfer_req,
  input logic                  cap_en_o,
  input logic [ENSEL_W-1:0]    en_src_o,
  input logic [CNT_W-1:0]      cnt_o
);

  p_req_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    xfer_req |=> !xfer_req);

  p_cnt_stop_r10: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == '0) && !wr_en |=> (cnt_o == '0));

  p_exhaust_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && ($past(cnt_o) == CNT_W'(1)) && (cnt_o == '0))
      |-> (!cap_en_o && xfer_req));

  p_no_sw_set_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr && wr_data[0] && (wr_data[ENSEL_W:1] != '0)
      && !cap_en_o && (rise_v == '0)) |=> !cap_en_o);

  p_none_src_r5: assert property (@(posedge clk) disable iff (rst)
    (en_src_o == '0) && !cap_en_o && !wr_en |=> !cap_en_o);

  p_disarm_r6: assert property (@(posedge clk) disable iff (rst)
    (dis_sel != 2'd0) && rise_v[dis_sel] && !wr_en |=> (en_src_o == '0));

endmodule

bind pcap_top pcap_top_chk #(.ENSEL_W(ENSEL_W), .CNT_W(CNT_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .rise_v(rise_v), .dis_sel(dis_sel),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .xfer_req(xfer_req), .cap_en_o(cap_en_o), .en_src_o(en_src_o), .cnt_o(cnt_o)
);

// File: tb/pcap_top_test.sv
module pcap_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  evt_i = '0;
  logic [31:0] data_i = '0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        xfer_req;
  logic [31:0] xfer_data;
  logic        cap_en_o;
  logic [2:0]  en_src_o;
  logic [3:0]  cnt_o;

  int errs = 0, checks = 0, nrx = 0;
  logic [31:0] rx [0:63];

  always #5 clk = ~clk;

  pcap_top #(.ENSEL_W(3), .CNT_W(4), .WORD_W(32)) uut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .data_i(data_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .xfer_req(xfer_req), .xfer_data(xfer_data),
    .cap_en_o(cap_en_o), .en_src_o(en_src_o), .cnt_o(cnt_o)
  );

  always @(negedge clk) begin
    if (!rst && xfer_req === 1'b1 && nrx < 64) begin
      rx[nrx] = xfer_data;
      nrx = nrx + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dv(input int j);
    return 32'h1A2B3C4D + 32'(j) * 32'h01030507;
  endfunction

  function automatic logic [31:0] expw(input int w, input int k, input int n);
    int L;
    logic [31:0] r, d;
    L = (w == 0) ? 4 : (w == 1) ? 2 : 1;
    r = '0;
    for (int i = 0; i < L; i++) begin
      if (k * L + i < n) begin
        d = dv(k * L + i);
        if (w == 0)      r[i*8 +: 8]   = d[7:0];
        else if (w == 1) r[i*16 +: 16] = d[15:0];
        else             r = d;
      end
    end
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; evt_i = '0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    nrx = 0;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ctl(input int en, input int es, input int ds, input int w, input int cs);
    wr(1'b0, 32'((cs << 8) | (w << 6) | (ds << 4) | (es << 1) | en));
  endtask

  task automatic pulse(input int line, input logic [31:0] d);
    data_i = d;
    evt_i[line] = 1'b1;
    repeat (3) @(negedge clk);
    evt_i[line] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int exp_n, L;
    do_reset();
    // R1 reset state
    chk("R1 xfer_req", 32'(xfer_req), 0);
    chk("R1 cap_en", 32'(cap_en_o), 0);
    chk("R1 en_src", 32'(en_src_o), 0);
    chk("R1 cnt", 32'(cnt_o), 0);

    // R9 R10 sweep of width codes and counts
    for (int w = 0; w < 4; w++) begin
      for (int n = 1; n <= 6; n++) begin
        do_reset();
        wr(1'b1, 32'(n));
        ctl(1, 0, 0, w, 0);
        for (int j = 0; j < n; j++) pulse(0, dv(j));
        repeat (4) @(negedge clk);
        L = (w == 0) ? 4 : (w == 1) ? 2 : 1;
        exp_n = (n + L - 1) / L;
        chk($sformatf("R9 count w=%0d n=%0d", w, n), 32'(nrx), 32'(exp_n));
        for (int k = 0; k < exp_n && k < nrx; k++)
          chk($sformatf("R9 word w=%0d n=%0d k=%0d", w, n, k), rx[k], expw(w, k, n));
        chk("R10 enable dropped", 32'(cap_en_o), 0);
        chk("R10 counter zero", 32'(cnt_o), 0);
        pulse(0, 32'hDEADBEEF);
        chk("R10 no capture after exhaustion", 32'(nrx), 32'(exp_n));
      end
    end

    // R2 latency: request at edge k+2
    do_reset();
    wr(1'b1, 32'd1);
    ctl(1, 0, 0, 2, 0);
    data_i = dv(7);
    evt_i[0] = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 no request after edge k", 32'(xfer_req), 0);
    @(posedge clk); @(negedge clk);
    chk("R2 no request after edge k+1", 32'(xfer_req), 0);
    @(posedge clk); @(negedge clk);
    chk("R2 request after edge k+2", 32'(xfer_req), 1);
    chk("R2 data", xfer_data, dv(7));
    evt_i[0] = 1'b0;
    repeat (3) @(negedge clk);

    // R3 software set and clear
    do_reset();
    ctl(1, 0, 0, 2, 0);
    chk("R3 set", 32'(cap_en_o), 1);
    ctl(0, 0, 0, 2, 0);
    chk("R3 clear", 32'(cap_en_o), 0);

    // R7 no capture while disabled
    do_reset();
    wr(1'b1, 32'd5);
    ctl(0, 0, 0, 2, 0);
    pulse(0, dv(1));
    chk("R7 disabled no request", 32'(nrx), 0);
    chk("R7 disabled counter kept", 32'(cnt_o), 5);

    // R7 line select
    do_reset();
    wr(1'b1, 32'd3);
    ctl(1, 0, 0, 2, 1);
    pulse(0, dv(2));
    chk("R7 other line ignored", 32'(nrx), 0);
    chk("R7 counter kept", 32'(cnt_o), 3);
    pulse(1, dv(3));
    chk("R7 selected line captured", 32'(nrx), 1);
    chk("R7 captured data", rx[0], dv(3));
    chk("R7 counter decremented", 32'(cnt_o), 2);

    // R4 R5 hardware enable source
    do_reset();
    wr(1'b1, 32'd4);
    ctl(1, 3, 0, 2, 0);
    chk("R4 software set ignored", 32'(cap_en_o), 0);
    pulse(3, dv(0));
    chk("R5 event sets enable", 32'(cap_en_o), 1);
    chk("R5 enabling event not captured on other line", 32'(nrx), 0);
    pulse(0, dv(4));
    chk("R5 capture after hw enable", rx[0], dv(4));

    // R5 none selected
    do_reset();
    wr(1'b1, 32'd4);
    ctl(0, 0, 0, 2, 0);
    for (int l = 1; l < 8; l++) pulse(l, dv(l));
    chk("R5 none never sets", 32'(cap_en_o), 0);

    // R8 same-cycle enable and capture
    do_reset();
    wr(1'b1, 32'd2);
    ctl(0, 2, 0, 2, 2);
    pulse(2, dv(5));
    chk("R8 enable set", 32'(cap_en_o), 1);
    chk("R8 captured", 32'(nrx), 1);
    chk("R8 data", rx[0], dv(5));
    chk("R8 counter", 32'(cnt_o), 1);

    // R6 disarm
    do_reset();
    wr(1'b1, 32'd2);
    ctl(0, 3, 1, 2, 0);
    chk("R6 armed", 32'(en_src_o), 3);
    pulse(1, dv(0));
    chk("R6 source cleared", 32'(en_src_o), 0);
    pulse(3, dv(0));
    chk("R6 disarmed no enable", 32'(cap_en_o), 0);

    // R11 software clear discards partial word
    do_reset();
    wr(1'b1, 32'd10);
    ctl(1, 0, 0, 0, 0);
    pulse(0, dv(20));
    pulse(0, dv(21));
    ctl(0, 0, 0, 0, 0);
    chk("R11 no request on clear", 32'(nrx), 0);
    ctl(1, 0, 0, 0, 0);
    for (int j = 0; j < 4; j++) pulse(0, dv(j));
    chk("R11 one word", 32'(nrx), 1);
    chk("R11 fresh lanes", rx[0], expw(0, 0, 4));
    chk("R11 counter", 32'(cnt_o), 4);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule